// File: doc/BRIEF.md
# UART Interrupt Enable and Line-Status Register

This block is the interrupt control and status byte of a UART. It holds four writable enable bits beside four read-only status bits, and it drives one level-sensitive interrupt request. The status bits are the transmit-buffer-empty flag, the receive-buffer-full flag, the present clear-to-send level and a sticky change flag for clear-to-send.

The buffer flags are set and cleared by single-cycle pulses from the surrounding UART datapath. The receive-error condition arrives as a level from elsewhere. The clear-to-send pin passes through two synchronizing flops. Any change on the synchronized level sets the change flag, and that flag holds until the CPU reads the register. When the flow-control enable is on, a clear-to-set transition of the change flag raises a flow-control interrupt. That interrupt stays pending until the flag is cleared by a read.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the register reads 8'h01. Only bit 0 (transmit buffer empty) is set and the interrupt request is low.
- R2: Bit 3 reads 1 while the synchronized clear-to-send pin is low and 0 while it is high. A pin change appears on bit 3 two clock edges after it is presented.
- R3: Any change of the synchronized clear-to-send level sets bit 2 one edge later. Bit 2 then stays set until a register read.
- R4: A register read clears bit 2. If a clear-to-send change is detected at the same edge as the read, bit 2 stays set.
- R5: A write updates only bits 7:4. The layout is bit 7 error enable, bit 6 receive enable, bit 5 transmit enable, bit 4 flow-control enable. Write data in bits 3:0 has no effect.
- R6: Bit 0 is set by a buffer-empty pulse and cleared by a buffer-load pulse. Bit 1 is set by a receive-complete pulse and cleared by a buffer-read pulse. When set and clear arrive in the same cycle, set wins.
- R7: The interrupt request is high whenever bit 0 is set with bit 5 on, or bit 1 is set with bit 6 on, or the error level is high with bit 7 on.
- R8: With bit 4 on, a clear-to-set transition of bit 2 makes a flow-control interrupt pending. It stays pending until bit 2 is cleared by a read. Turning bit 4 on while bit 2 is already set raises nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Asynchronous clear-to-send pin, active low |
| tx_emptied | input | 1 | Pulse: transmit data moved to shifter, sets bit 0 |
| tx_filled | input | 1 | Pulse: transmit buffer written, clears bit 0 |
| rx_filled | input | 1 | Pulse: received frame stored, sets bit 1 |
| rx_drained | input | 1 | Pulse: receive buffer read, clears bit 1 |
| rx_err | input | 1 | Receive error level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Register value |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that the clear-to-send pin is held for at least three clock cycles between changes. With that spacing, each change on the synchronized level can be matched against the visible bit 3 history. They also assume that the read and write strobes are never asserted together. The bench steps every input at a falling edge and holds the pin well beyond that window between toggles. It keeps read and write in separate cycles. Buffer pulses last exactly one cycle, except in the deliberate set-and-clear collision case.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n_pin,
  input  logic       tx_emptied,
  input  logic       tx_filled,
  input  logic       rx_filled,
  input  logic       rx_drained,
  input  logic       rx_err,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq
);

  logic [SYNC_STAGES-1:0] cts_sync;
  logic       cts_prev;
  logic [3:0] enables;
  logic       tbe, rbf, dcts, fc_pend;
  logic       cts_now, cts_changed;

  assign cts_now     = cts_sync[SYNC_STAGES-1];
  assign cts_changed = cts_now != cts_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_sync <= '1;
      cts_prev <= 1'b1;
    end else begin
      cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n_pin};
      cts_prev <= cts_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enables <= 4'h0;
      tbe     <= 1'b1;
      rbf     <= 1'b0;
      dcts    <= 1'b0;
      fc_pend <= 1'b0;
    end else begin
      if (wr_en) enables <= wr_data[7:4];

      if (tx_emptied)     tbe <= 1'b1;
      else if (tx_filled) tbe <= 1'b0;

      if (rx_filled)       rbf <= 1'b1;
      else if (rx_drained) rbf <= 1'b0;

      if (cts_changed) dcts <= 1'b1;
      else if (rd_en)  dcts <= 1'b0;

      if (cts_changed && !dcts && enables[0]) fc_pend <= 1'b1;
      else if (rd_en && !cts_changed)         fc_pend <= 1'b0;
    end
  end

  assign rd_data = {enables, ~cts_now, dcts, rbf, tbe};

  assign irq = (tbe & enables[1]) | (rbf & enables[2]) |
               (rx_err & enables[3]) | fc_pend;

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_emptied,
  input logic       rx_err,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       irq
);

  assert_change_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] != $past(rd_data[3])) |=> rd_data[2]);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_data[3] == $past(rd_data[3])) |=> !rd_data[2]);

  assert_write_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[7:4] == $past(wr_data[7:4]));

  assert_empty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emptied |=> rd_data[0]);

  assert_irq_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && rd_data[5]) |-> irq);

  assert_irq_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && rd_data[7]) |-> irq);

  assert_fc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] && rd_data[7:5] == 3'b000) |-> !irq);

endmodule

bind uart_irq_status uart_irq_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tx_emptied(tx_emptied), .rx_err(rx_err),
  .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
  .irq(irq)
);

// File: tb/test_uart_irq_status.sv
`timescale 1ns/1ps
module test_uart_irq_status;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n_pin = 1'b1;
  logic tx_emptied = 0, tx_filled = 0, rx_filled = 0, rx_drained = 0, rx_err = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin),
    .tx_emptied(tx_emptied), .tx_filled(tx_filled),
    .rx_filled(rx_filled), .rx_drained(rx_drained), .rx_err(rx_err),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic rd();
    rd_en = 1; step(1); rd_en = 0;
  endtask

  task automatic t_reset();
    chk("R1", {irq, rd_data}, {1'b0, 8'h01});
  endtask

  task automatic t_cts_track();
    cts_n_pin = 0; step(1);
    chk("R2", {8'h0, rd_data[3]}, 9'h0);
    step(1);
    chk("R2", {8'h0, rd_data[3]}, 9'h1);
    chk("R3", {8'h0, rd_data[2]}, 9'h0);
    step(1);
    chk("R3", {8'h0, rd_data[2]}, 9'h1);
    step(4);
    chk("R3", {8'h0, rd_data[2]}, 9'h1);
    rd();
    chk("R4", {8'h0, rd_data[2]}, 9'h0);
  endtask

  task automatic t_collision();
    cts_n_pin = 1; step(2);
    chk("R2", {8'h0, rd_data[3]}, 9'h0);
    chk("R4", {8'h0, rd_data[2]}, 9'h0);
    rd();
    chk("R4", {8'h0, rd_data[2]}, 9'h1);
    rd();
    chk("R4", {8'h0, rd_data[2]}, 9'h0);
  endtask

  task automatic t_write_mask();
    wr(8'h0F);
    chk("R5", {1'b0, rd_data}, {1'b0, 8'h01});
    wr(8'hA4);
    chk("R5", {1'b0, rd_data}, {1'b0, 8'hA1});
    wr(8'h00);
  endtask

  task automatic t_enables();
    chk("R7", {8'h0, irq}, 9'h0);
    wr(8'h20);
    chk("R7", {8'h0, irq}, 9'h1);
    tx_filled = 1; step(1); tx_filled = 0;
    chk("R6", {1'b0, rd_data}, {1'b0, 8'h20});
    chk("R7", {8'h0, irq}, 9'h0);
    tx_emptied = 1; step(1); tx_emptied = 0;
    chk("R6", {8'h0, rd_data[0]}, 9'h1);
    wr(8'h40);
    chk("R7", {8'h0, irq}, 9'h0);
    rx_filled = 1; step(1); rx_filled = 0;
    chk("R6", {8'h0, rd_data[1]}, 9'h1);
    chk("R7", {8'h0, irq}, 9'h1);
    rx_drained = 1; step(1); rx_drained = 0;
    chk("R6", {8'h0, rd_data[1]}, 9'h0);
    chk("R7", {8'h0, irq}, 9'h0);
    rx_filled = 1; rx_drained = 1; tx_emptied = 1; tx_filled = 1; step(1);
    rx_filled = 0; rx_drained = 0; tx_emptied = 0; tx_filled = 0;
    chk("R6", {7'h0, rd_data[1:0]}, 9'h3);
    rx_drained = 1; step(1); rx_drained = 0;
    wr(8'h80);
    chk("R7", {8'h0, irq}, 9'h0);
    rx_err = 1; step(1);
    chk("R7", {8'h0, irq}, 9'h1);
    wr(8'h00);
    chk("R7", {8'h0, irq}, 9'h0);
    rx_err = 0;
  endtask

  task automatic t_flow();
    wr(8'h10);
    cts_n_pin = 0; step(2);
    chk("R8", {8'h0, irq}, 9'h0);
    step(1);
    chk("R8", {8'h0, irq}, 9'h1);
    step(3);
    chk("R8", {8'h0, irq}, 9'h1);
    rd();
    chk("R8", {8'h0, irq}, 9'h0);
    wr(8'h00);
    cts_n_pin = 1; step(3);
    chk("R3", {8'h0, rd_data[2]}, 9'h1);
    chk("R8", {8'h0, irq}, 9'h0);
    wr(8'h10);
    step(1);
    chk("R8", {8'h0, irq}, 9'h0);
    rd();
    chk("R8", {8'h0, irq}, 9'h0);
    wr(8'h00);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_cts_track();
    t_collision();
    t_write_mask();
    t_enables();
    t_flow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule